// File: doc/BRIEF.md
# Integrating Converter Timing Sequencer

This block is the digital core of a charge-balancing integrating light-to-digital converter with two input channels. An external comparator emits a balance pulse each time a packet of charge is removed from the integrator. The sequencer counts those pulses over an integration window and turns the count into a 16-bit result. It also reports how many oscillator ticks the window lasted. It drives a channel-select line so that the front end routes the chosen photodiode to the shared integrator.

The window comes from one of two sources. In internal timing, windows repeat back to back, and each one ends when a counter of selectable length (4, 8, 12 or 16 bits) has counted its full span of oscillator ticks. In external timing, a sync command opens the first window. Each later command closes the current window, publishes its values and opens the next window at once. A subtract mode converts channel 1 and then channel 2, and reports the first value minus the second. A range setting scales the pulse count for conditions from dim to bright.

Top module: `conv_sequencer`

## Requirements
- R1: `chan_mode` = 0 (code 2 behaves the same way) converts channel 1 alone: `chan2_sel` stays low and the result is the number of balance pulses counted in the window, scaled as in R8.
- R2: `chan_mode` = 1 converts channel 2 alone: `chan2_sel` stays high and the result is the scaled pulse count taken while channel 2 was selected.
- R3: `chan_mode` = 3 runs a channel 1 window with `chan2_sel` low and then a channel 2 window with `chan2_sel` high. `done` is raised only after the second window, and the result is the channel 1 value minus the channel 2 value. In internal timing with 16-tick windows and one tick per clock, `done` rises on the 33rd rising edge after `run` is first sampled high.
- R4: In subtract mode, a channel 2 value larger than the channel 1 value gives a result of 0.
- R5: In internal timing (`ext_mode` = 0), each window lasts 2^(4·(`len_sel`+1)) ticks of `osc_tick`, and the windows repeat while `run` is high. The first window begins in the clock after `run` is first sampled high, so with one tick per clock a single-channel `done` rises on the 17th rising edge for `len_sel` = 0.
- R6: In external timing (`ext_mode` = 1), the first `sync_cmd` only opens a window. Each later `sync_cmd` closes the window, including that cycle's tick and pulse, latches the outputs and opens the next window in the same clock.
- R7: `cycles` holds the number of `osc_tick` cycles in the window that produced the result, and saturates at 0xFFFF.
- R8: The result is the pulse count multiplied by 4^`range_sel`, and saturates at 0xFFFF.
- R9: `done` is high for exactly one clock, in the cycle after the new `result` and `cycles` are latched. Outside such cycles, `result` and `cycles` hold the latest completed conversion.
- R10: Dropping `run` abandons the current window and any pending first pass of a subtract conversion. No `done` follows, and `result` and `cycles` keep their values.
- R11: After reset `result`, `cycles`, `done` and `chan2_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables conversion; low aborts and idles |
| ext_mode | input | 1 | 0: internal timing, 1: windows bounded by sync commands |
| sync_cmd | input | 1 | One-clock external timing command |
| osc_tick | input | 1 | One-clock tick from the internal oscillator |
| bal_pulse | input | 1 | One-clock charge-balance pulse from the comparator |
| chan_mode | input | 2 | 0/2: channel 1, 1: channel 2, 3: channel 1 minus channel 2 |
| len_sel | input | 2 | Internal window counter length, 4·(len_sel+1) bits |
| range_sel | input | 2 | Scaling of the pulse count by 4^range_sel |
| chan2_sel | output | 1 | Routes channel 2 to the integrator when high |
| result | output | 16 | Latest completed conversion result |
| cycles | output | 16 | Oscillator ticks in the window of the latest result |
| done | output | 1 | One-clock pulse when result and cycles update |

## Verification
The assertions check the following on every cycle: the outputs hold their values between `done` pulses; `done` only follows a cycle with `run` high; every internally timed result carries the tick count its counter length requires; channel 1 mode never selects channel 2; and the switch from the first to the second subtract pass never publishes a result. Only the bench scenarios can show the values themselves. These cover the pulse counts per channel, the scaling and its saturation, the saturation of the difference at zero, the 16-bit tick count limit, the latency from `run` to the first result, and the first sync command opening a window without publishing anything.

// File: rtl/conv_sequencer.sv
`timescale 1ns/1ps
module conv_sequencer #(
  parameter int W    = 16,
  parameter int STEP = 4,
  parameter int RS   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         ext_mode,
  input  logic         sync_cmd,
  input  logic         osc_tick,
  input  logic         bal_pulse,
  input  logic [1:0]   chan_mode,
  input  logic [1:0]   len_sel,
  input  logic [1:0]   range_sel,
  output logic         chan2_sel,
  output logic [W-1:0] result,
  output logic [W-1:0] cycles,
  output logic         done
);
  localparam int CW = 4 * STEP + 1;
  localparam int SW = W + 3 * RS;

  logic          active, pass;
  logic [CW-1:0] ticks, ticks_n, limit;
  logic [W-1:0]  acc, acc_n, first, scaled, diff, tick_out;
  logic [SW-1:0] wide;
  logic          subtract, win_end;

  assign subtract = (chan_mode == 2'd3);
  assign chan2_sel = (chan_mode == 2'd1) || (subtract && pass);

  assign ticks_n = (osc_tick && !(&ticks)) ? ticks + CW'(1) : ticks;
  assign acc_n   = (bal_pulse && !(&acc)) ? acc + W'(1) : acc;
  assign limit   = CW'(1) << (STEP * (int'(len_sel) + 1));

  assign win_end = active && (ext_mode ? sync_cmd : (osc_tick && ticks_n == limit));

  assign wide     = SW'(acc_n) << (RS * int'(range_sel));
  assign scaled   = ((wide >> W) != '0) ? '1 : W'(wide);
  assign diff     = (first >= scaled) ? first - scaled : '0;
  assign tick_out = ((ticks_n >> W) != '0) ? '1 : W'(ticks_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pass   <= 1'b0;
      ticks  <= '0;
      acc    <= '0;
      first  <= '0;
      result <= '0;
      cycles <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        active <= 1'b0;
        pass   <= 1'b0;
        ticks  <= '0;
        acc    <= '0;
      end else if (!active) begin
        active <= !ext_mode || sync_cmd;
        pass   <= 1'b0;
        ticks  <= '0;
        acc    <= '0;
      end else if (win_end) begin
        ticks <= '0;
        acc   <= '0;
        if (subtract && !pass) begin
          first <= scaled;
          pass  <= 1'b1;
        end else begin
          pass   <= 1'b0;
          result <= subtract ? diff : scaled;
          cycles <= tick_out;
          done   <= 1'b1;
        end
      end else begin
        ticks <= ticks_n;
        acc   <= acc_n;
      end
    end
  end
endmodule

// File: rtl/conv_sequencer_chk.sv
`timescale 1ns/1ps
module conv_sequencer_chk #(
  parameter int W    = 16,
  parameter int STEP = 4,
  parameter int RS   = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         ext_mode,
  input logic         sync_cmd,
  input logic         osc_tick,
  input logic         bal_pulse,
  input logic [1:0]   chan_mode,
  input logic [1:0]   len_sel,
  input logic [1:0]   range_sel,
  input logic         chan2_sel,
  input logic [W-1:0] result,
  input logic [W-1:0] cycles,
  input logic         done
);
  function automatic logic [W-1:0] span(input logic [1:0] s);
    longint v;
    v = longint'(1) << (STEP * (int'(s) + 1));
    return (v > ((longint'(1) << W) - 1)) ? '1 : W'(v);
  endfunction

  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(cycles))); // R9
  AST_DONE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(run)); // R10
  AST_INTERNAL_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(ext_mode)) |-> (cycles == span($past(len_sel)))); // R5
  AST_CH1_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_mode == 2'd0) |-> !chan2_sel); // R1
  AST_FIRST_PASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_mode == 2'd3) && $rose(chan2_sel)) |-> !done); // R3
endmodule

bind conv_sequencer conv_sequencer_chk #(.W(W), .STEP(STEP), .RS(RS)) u_chk (.*);

// File: tb/test_conv_sequencer.sv
`timescale 1ns/1ps
module test_conv_sequencer;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, ext_mode = 1'b0, sync_cmd = 1'b0;
  logic [1:0] chan_mode = '0, len_sel = '0, range_sel = '0;
  logic osc_tick, bal_pulse, chan2_sel, done;
  logic [W-1:0] result, cycles;
  int tick_div = 1, p1_div = 0, p2_div = 0, cyc = 0;
  int checks = 0, errors = 0;

  assign osc_tick  = (tick_div > 0) && (cyc % tick_div == 0);
  assign bal_pulse = chan2_sel ? ((p2_div > 0) && (cyc % p2_div == 0))
                               : ((p1_div > 0) && (cyc % p1_div == 0));

  always #2.5 clk = ~clk;

  conv_sequencer i_conv_sequencer (.*);

  // behavioural reference model
  int m_active, m_pass, m_ticks, m_pulses, m_first, m_res, m_cyc, m_val, m_done;
  bit m_end;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_pass = 0; m_ticks = 0; m_pulses = 0;
      m_first = 0; m_res = 0; m_cyc = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (!run) begin
        m_active = 0; m_pass = 0; m_ticks = 0; m_pulses = 0;
      end else if (m_active == 0) begin
        if (!ext_mode || sync_cmd) m_active = 1;
        m_pass = 0; m_ticks = 0; m_pulses = 0;
      end else begin
        m_ticks  += int'(osc_tick);
        m_pulses += int'(bal_pulse);
        m_end = ext_mode ? sync_cmd
                         : (osc_tick && m_ticks == (1 << (4 * (int'(len_sel) + 1))));
        if (m_end) begin
          m_val = m_pulses << (2 * int'(range_sel));
          if (m_val > 65535) m_val = 65535;
          if (chan_mode == 2'd3 && m_pass == 0) begin
            m_first = m_val; m_pass = 1;
          end else begin
            m_res  = (chan_mode == 2'd3) ? ((m_first > m_val) ? m_first - m_val : 0) : m_val;
            m_cyc  = (m_ticks > 65535) ? 65535 : m_ticks;
            m_done = 1; m_pass = 0;
          end
          m_ticks = 0; m_pulses = 0;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R8 result vs model", int'(result), m_res);
      chk("R7 cycles vs model", int'(cycles), m_cyc);
      chk("R9 done vs model", int'(done), m_done);
      chk("R2 chan2_sel vs model", int'(chan2_sel),
          int'(chan_mode == 2'd1 || (chan_mode == 2'd3 && m_pass == 1)));
    end
  end

  task automatic setup(bit ext, logic [1:0] mode, logic [1:0] len, logic [1:0] rng,
                       int td, int d1, int d2);
    @(posedge clk); #1;
    run = 1'b0; ext_mode = ext; chan_mode = mode; len_sel = len; range_sel = rng;
    tick_div = td; p1_div = d1; p2_div = d2;
    @(posedge clk); #1;
    run = 1'b1;
  endtask

  task automatic wait_done(output int waited);
    waited = 0;
    do begin
      @(posedge clk); #1;
      waited++;
    end while (!done);
  endtask

  task automatic tick_cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w;
    int seen;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset result", int'(result), 0);
    chk("R11 reset cycles", int'(cycles), 0);
    chk("R11 reset done", int'(done), 0);
    chk("R11 reset chan2_sel", int'(chan2_sel), 0);
    rst_n = 1'b1;

    setup(0, 2'd0, 2'd0, 2'd0, 1, 1, 0);
    wait_done(w);
    chk("R5 latency len 4", w, 17);
    chk("R1 ch1 result", int'(result), 16);
    chk("R5 cycles len 4", int'(cycles), 16);
    chk("R1 ch1 select low", int'(chan2_sel), 0);
    tick_cycles(1);
    chk("R9 done one clock", int'(done), 0);
    chk("R9 result held", int'(result), 16);

    setup(0, 2'd0, 2'd1, 2'd0, 1, 1, 0);
    wait_done(w);
    chk("R5 result len 8", int'(result), 256);
    chk("R5 cycles len 8", int'(cycles), 256);

    setup(0, 2'd0, 2'd0, 2'd1, 1, 1, 0);
    wait_done(w);
    chk("R8 range 1", int'(result), 64);
    setup(0, 2'd0, 2'd1, 2'd3, 1, 1, 0);
    wait_done(w);
    chk("R8 range 3", int'(result), 16384);
    setup(0, 2'd0, 2'd2, 2'd3, 1, 1, 0);
    wait_done(w);
    chk("R8 range saturates", int'(result), 65535);
    chk("R5 cycles len 12", int'(cycles), 4096);

    setup(0, 2'd0, 2'd3, 2'd0, 1, 1, 0);
    wait_done(w);
    chk("R7 cycles saturate", int'(cycles), 65535);
    chk("R8 count saturates", int'(result), 65535);

    setup(0, 2'd1, 2'd0, 2'd0, 1, 1, 2);
    wait_done(w);
    chk("R2 ch2 result", int'(result), 8);
    chk("R2 ch2 select high", int'(chan2_sel), 1);

    setup(0, 2'd3, 2'd0, 2'd0, 1, 1, 2);
    wait_done(w);
    chk("R3 two-pass latency", w, 33);
    chk("R3 difference", int'(result), 8);
    chk("R3 back on ch1", int'(chan2_sel), 0);

    setup(0, 2'd3, 2'd0, 2'd0, 1, 2, 1);
    wait_done(w);
    chk("R4 negative clamps", int'(result), 0);

    setup(1, 2'd0, 2'd0, 2'd0, 1, 1, 0);
    tick_cycles(5);
    chk("R6 idle before sync", int'(done), 0);
    sync_cmd = 1'b1;
    tick_cycles(1);
    sync_cmd = 1'b0;
    chk("R6 first sync only starts", int'(done), 0);
    tick_cycles(9);
    sync_cmd = 1'b1;
    tick_cycles(1);
    sync_cmd = 1'b0;
    chk("R6 second sync latches", int'(done), 1);
    chk("R6 ext cycles", int'(cycles), 10);
    chk("R6 ext result", int'(result), 10);
    tick_cycles(5);
    sync_cmd = 1'b1;
    tick_cycles(1);
    sync_cmd = 1'b0;
    chk("R6 next window back to back", int'(cycles), 6);

    setup(0, 2'd0, 2'd1, 2'd0, 1, 1, 0);
    tick_cycles(50);
    run = 1'b0;
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1;
      if (done) seen++;
    end
    chk("R10 abort no done", seen, 0);
    chk("R10 result kept", int'(result), 6);
    chk("R10 cycles kept", int'(cycles), 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule